// File: doc/BRIEF.md
# Coprocessor Control Register Window

This block is the host-facing control surface of a small programmable coprocessor. The host reaches it through a 1 KB byte window and passes in only the low 10 bits of its address; every location in that window maps to one byte. Behind the window sit the block-transfer setup (source, length, destination), the program fetch setup (offset, page, program counter byte), five narrow configuration fields, a read-only status byte, a 32-byte vector table, and sixteen 24-bit general registers that are reached one byte lane at a time.

Two writes do more than store a byte. Writing the most significant destination byte asks the transfer engine to run, and writing the program counter byte starts the core at page × 256 + byte. Both take effect only while the core reports itself halted. The block drives a one-cycle transfer request, a one-cycle start pulse and the start address. It takes the halted indication from the core. The transfer engine and the core are not part of this block.

Reads are combinational on the offset. A write is taken on the rising clock edge while the write strobe is high.

Top module: `cop_regwin`

## Requirements
- R1: The transfer source is 24 bits at offsets 0x340 (low), 0x341 and 0x342 (high). The transfer length is 16 bits at 0x343 (low) and 0x344 (high). The transfer destination is 24 bits at 0x345 (low), 0x346 and 0x347 (high). Each byte reads back what was last written to it.
- R2: A write to 0x347 while `core_halted` is 1 drives `xfer_req` high for exactly the one cycle after the write edge. A write to 0x347 while `core_halted` is 0 gives no request, and neither does a write to any other destination byte.
- R3: The program offset is 24 bits at 0x349 (low), 0x34A and 0x34B (high) and reads back in full. The page number is 15 bits: 0x34D holds its low byte, and 0x34E holds bits 14:8, taken from data bits 6:0, so bit 7 of 0x34E always reads 0.
- R4: A write to 0x34F stores the program counter byte. If `core_halted` is 1 at that write, `start_pulse` is high for the one following cycle and `start_pc` equals page × 256 + the written byte (page in bits 22:8). No start pulse follows when the core is running.
- R5: The configuration bytes keep only their defined bits: 0x348 keeps bit 0, 0x34C keeps bits 1:0, 0x350 keeps data AND 0x77, and 0x351 and 0x352 each keep bit 0. Undefined bits read 0.
- R6: Any read from 0x353 through 0x35F returns status: 0x40 while `core_halted` is 0 and 0x02 while it is 1. Writes there store nothing.
- R7: Offsets 0x360 to 0x37F form a 32-entry byte table that can be read and written, selected by offset bits 4:0.
- R8: Offsets 0x380 to 0x3AF and 0x3C0 to 0x3EF both reach the same sixteen 24-bit registers. The register is (offset bits 5:0) / 3 and the byte lane is the remainder, with lane 0 the least significant byte.
- R9: Every other offset (0x000 to 0x33F, 0x3B0 to 0x3BF, 0x3F0 to 0x3FF) reads 0x00, and a write there changes no readable byte.
- R10: After reset every stored field reads 0, and `xfer_req`, `start_pulse` and `start_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_ofs | input | 10 | Byte offset within the 1 KB window (low host address bits) |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte for `win_ofs`, combinational |
| core_halted | input | 1 | 1 while the core is halted |
| xfer_req | output | 1 | One-cycle request to the transfer engine |
| start_pulse | output | 1 | One-cycle command that starts the core |
| start_pc | output | 23 | Start address, valid with `start_pulse` |

## Verification
Each store range is written with a distinct value at every byte, so a swapped lane, a wrong register index or a lost mask shows up as a wrong readback rather than a coincidental match. The general registers are written through one mirror and read through the other, which separates the divide-by-three index from the plain offset. Both trigger bytes are written with the core halted and with it running, which tells a missing halt condition apart from a missing pulse. A full sweep of all 1024 offsets after writes to unmapped and status offsets shows that those writes left every readable byte alone.

// File: rtl/cop_regwin_pkg.sv
`timescale 1ns/1ps
package cop_regwin_pkg;

    parameter int WIN_W   = 10;
    parameter int BYTE_W  = 8;
    parameter int GPR_N   = 16;
    parameter int GPR_W   = 24;
    parameter int VEC_N   = 32;
    parameter int PAGE_W  = 15;
    parameter int XADDR_W = 24;
    parameter int XLEN_W  = 16;

    localparam int GPR_IW  = $clog2(GPR_N);
    localparam int VEC_IW  = $clog2(VEC_N);
    localparam int LANES   = GPR_W / BYTE_W;
    localparam int LANE_W  = 2;
    localparam int SPC_W   = PAGE_W + BYTE_W;

    // control byte offsets inside the window
    localparam logic [WIN_W-1:0] O_SRC0  = 10'h340;
    localparam logic [WIN_W-1:0] O_SRC1  = 10'h341;
    localparam logic [WIN_W-1:0] O_SRC2  = 10'h342;
    localparam logic [WIN_W-1:0] O_LEN0  = 10'h343;
    localparam logic [WIN_W-1:0] O_LEN1  = 10'h344;
    localparam logic [WIN_W-1:0] O_DST0  = 10'h345;
    localparam logic [WIN_W-1:0] O_DST1  = 10'h346;
    localparam logic [WIN_W-1:0] O_DST2  = 10'h347;
    localparam logic [WIN_W-1:0] O_CFGA  = 10'h348;
    localparam logic [WIN_W-1:0] O_POF0  = 10'h349;
    localparam logic [WIN_W-1:0] O_POF1  = 10'h34A;
    localparam logic [WIN_W-1:0] O_POF2  = 10'h34B;
    localparam logic [WIN_W-1:0] O_CFGB  = 10'h34C;
    localparam logic [WIN_W-1:0] O_PAGE0 = 10'h34D;
    localparam logic [WIN_W-1:0] O_PAGE1 = 10'h34E;
    localparam logic [WIN_W-1:0] O_PCB   = 10'h34F;
    localparam logic [WIN_W-1:0] O_CFGC  = 10'h350;
    localparam logic [WIN_W-1:0] O_CFGD  = 10'h351;
    localparam logic [WIN_W-1:0] O_CFGE  = 10'h352;
    localparam logic [WIN_W-1:0] O_STAT_LO = 10'h353;
    localparam logic [WIN_W-1:0] O_STAT_HI = 10'h35F;

    localparam logic [BYTE_W-1:0] CFGC_MASK = 8'h77;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTL,
        RG_STAT,
        RG_VEC,
        RG_GPR
    } region_e;

    typedef struct packed {
        logic [XADDR_W-1:0] src;
        logic [XLEN_W-1:0]  len;
        logic [XADDR_W-1:0] dst;
        logic [XADDR_W-1:0] pofs;
        logic [PAGE_W-1:0]  page;
        logic [BYTE_W-1:0]  pcb;
        logic               cfg_a;
        logic [1:0]         cfg_b;
        logic [BYTE_W-1:0]  cfg_c;
        logic               cfg_d;
        logic               cfg_e;
        logic               xreq;
        logic               start;
        logic [SPC_W-1:0]   spc;
    } ctl_t;

endpackage

// File: rtl/cop_regwin_decode.sv
`timescale 1ns/1ps
module cop_regwin_decode
    import cop_regwin_pkg::*;
(
    input  logic [WIN_W-1:0]  win_ofs,
    output region_e           region,
    output logic [VEC_IW-1:0] vec_idx,
    output logic [GPR_IW-1:0] gpr_idx,
    output logic [LANE_W-1:0] gpr_lane
);

    logic [5:0] sub_ofs;
    logic       gpr_hit;

    assign sub_ofs = win_ofs[5:0];
    assign vec_idx = win_ofs[VEC_IW-1:0];

    // both general register ranges: upper nibble 0xE or 0xF, sub offset below 48
    assign gpr_hit = (win_ofs[9:7] == 3'b111) && (sub_ofs < 6'd48);

    always_comb begin
        region = RG_NONE;
        if (win_ofs >= O_SRC0 && win_ofs <= O_CFGE) begin
            region = RG_CTL;
        end else if (win_ofs >= O_STAT_LO && win_ofs <= O_STAT_HI) begin
            region = RG_STAT;
        end else if (win_ofs[9:5] == 5'b11011) begin
            region = RG_VEC;
        end else if (gpr_hit) begin
            region = RG_GPR;
        end
    end

    // quotient by three through a compare ladder; remainder from the low two bits
    always_comb begin
        gpr_idx = '0;
        for (int k = 1; k < GPR_N; k++) begin
            if (sub_ofs >= 6'(3 * k)) begin
                gpr_idx = GPR_IW'(k);
            end
        end
        gpr_lane = sub_ofs[1:0] - gpr_idx[1:0] - {gpr_idx[0], 1'b0};
    end

endmodule

// File: rtl/cop_regwin_gpr.sv
`timescale 1ns/1ps
module cop_regwin_gpr
    import cop_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [GPR_IW-1:0] idx,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [GPR_W-1:0] gpr_q [GPR_N];
    logic [GPR_W-1:0] gpr_d [GPR_N];

    always_comb begin
        for (int r = 0; r < GPR_N; r++) begin
            gpr_d[r] = gpr_q[r];
        end
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane == LANE_W'(l)) begin
                    gpr_d[idx][l*BYTE_W +: BYTE_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < GPR_N; r++) begin
                gpr_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < GPR_N; r++) begin
                gpr_q[r] <= gpr_d[r];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane == LANE_W'(l)) begin
                rdata = gpr_q[idx][l*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/cop_regwin_vec.sv
`timescale 1ns/1ps
module cop_regwin_vec
    import cop_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [VEC_IW-1:0] idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] vec_q [VEC_N];
    logic [BYTE_W-1:0] vec_d [VEC_N];

    always_comb begin
        for (int e = 0; e < VEC_N; e++) begin
            vec_d[e] = vec_q[e];
        end
        if (we) begin
            vec_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < VEC_N; e++) begin
                vec_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < VEC_N; e++) begin
                vec_q[e] <= vec_d[e];
            end
        end
    end

    assign rdata = vec_q[idx];

endmodule

// File: rtl/cop_regwin.sv
`timescale 1ns/1ps
module cop_regwin
    import cop_regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIN_W-1:0]  win_ofs,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              core_halted,
    output logic              xfer_req,
    output logic              start_pulse,
    output logic [SPC_W-1:0]  start_pc
);

    region_e           region;
    logic [VEC_IW-1:0] vec_idx;
    logic [GPR_IW-1:0] gpr_idx;
    logic [LANE_W-1:0] gpr_lane;
    logic [BYTE_W-1:0] vec_rd;
    logic [BYTE_W-1:0] gpr_rd;
    logic [BYTE_W-1:0] ctl_rd;
    logic [BYTE_W-1:0] stat_byte;

    ctl_t ctl_d;
    ctl_t ctl_q;

    cop_regwin_decode u_dec (
        .win_ofs  (win_ofs),
        .region   (region),
        .vec_idx  (vec_idx),
        .gpr_idx  (gpr_idx),
        .gpr_lane (gpr_lane)
    );

    cop_regwin_vec u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && (region == RG_VEC)),
        .idx   (vec_idx),
        .wdata (wr_data),
        .rdata (vec_rd)
    );

    cop_regwin_gpr u_gpr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && (region == RG_GPR)),
        .idx   (gpr_idx),
        .lane  (gpr_lane),
        .wdata (wr_data),
        .rdata (gpr_rd)
    );

    // next state of the control fields and the trigger pulses
    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.xreq  = 1'b0;
        ctl_d.start = 1'b0;
        if (wr_en && (region == RG_CTL)) begin
            unique case (win_ofs)
                O_SRC0:  ctl_d.src[7:0]   = wr_data;
                O_SRC1:  ctl_d.src[15:8]  = wr_data;
                O_SRC2:  ctl_d.src[23:16] = wr_data;
                O_LEN0:  ctl_d.len[7:0]   = wr_data;
                O_LEN1:  ctl_d.len[15:8]  = wr_data;
                O_DST0:  ctl_d.dst[7:0]   = wr_data;
                O_DST1:  ctl_d.dst[15:8]  = wr_data;
                O_DST2: begin
                    ctl_d.dst[23:16] = wr_data;
                    ctl_d.xreq       = core_halted;
                end
                O_CFGA:  ctl_d.cfg_a       = wr_data[0];
                O_POF0:  ctl_d.pofs[7:0]   = wr_data;
                O_POF1:  ctl_d.pofs[15:8]  = wr_data;
                O_POF2:  ctl_d.pofs[23:16] = wr_data;
                O_CFGB:  ctl_d.cfg_b       = wr_data[1:0];
                O_PAGE0: ctl_d.page[7:0]   = wr_data;
                O_PAGE1: ctl_d.page[14:8]  = wr_data[6:0];
                O_PCB: begin
                    ctl_d.pcb = wr_data;
                    if (core_halted) begin
                        ctl_d.start = 1'b1;
                        ctl_d.spc   = {ctl_q.page, wr_data};
                    end
                end
                O_CFGC:  ctl_d.cfg_c = wr_data & CFGC_MASK;
                O_CFGD:  ctl_d.cfg_d = wr_data[0];
                O_CFGE:  ctl_d.cfg_e = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ctl_rd = '0;
        unique case (win_ofs)
            O_SRC0:  ctl_rd = ctl_q.src[7:0];
            O_SRC1:  ctl_rd = ctl_q.src[15:8];
            O_SRC2:  ctl_rd = ctl_q.src[23:16];
            O_LEN0:  ctl_rd = ctl_q.len[7:0];
            O_LEN1:  ctl_rd = ctl_q.len[15:8];
            O_DST0:  ctl_rd = ctl_q.dst[7:0];
            O_DST1:  ctl_rd = ctl_q.dst[15:8];
            O_DST2:  ctl_rd = ctl_q.dst[23:16];
            O_CFGA:  ctl_rd = {7'd0, ctl_q.cfg_a};
            O_POF0:  ctl_rd = ctl_q.pofs[7:0];
            O_POF1:  ctl_rd = ctl_q.pofs[15:8];
            O_POF2:  ctl_rd = ctl_q.pofs[23:16];
            O_CFGB:  ctl_rd = {6'd0, ctl_q.cfg_b};
            O_PAGE0: ctl_rd = ctl_q.page[7:0];
            O_PAGE1: ctl_rd = {1'b0, ctl_q.page[14:8]};
            O_PCB:   ctl_rd = ctl_q.pcb;
            O_CFGC:  ctl_rd = ctl_q.cfg_c;
            O_CFGD:  ctl_rd = {7'd0, ctl_q.cfg_d};
            O_CFGE:  ctl_rd = {7'd0, ctl_q.cfg_e};
            default: ctl_rd = '0;
        endcase
    end

    // running flag in bit 6, halted flag in bit 1
    assign stat_byte = {1'b0, !core_halted, 4'd0, core_halted, 1'b0};

    always_comb begin
        unique case (region)
            RG_CTL:  rd_data = ctl_rd;
            RG_STAT: rd_data = stat_byte;
            RG_VEC:  rd_data = vec_rd;
            RG_GPR:  rd_data = gpr_rd;
            default: rd_data = '0;
        endcase
    end

    assign xfer_req    = ctl_q.xreq;
    assign start_pulse = ctl_q.start;
    assign start_pc    = ctl_q.spc;

endmodule

// File: rtl/cop_regwin_chk.sv
`timescale 1ns/1ps
module cop_regwin_chk
    import cop_regwin_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WIN_W-1:0]  win_ofs,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] rd_data,
    input logic              core_halted,
    input logic              xfer_req,
    input logic              start_pulse,
    input logic [SPC_W-1:0]  start_pc,
    input region_e           region
);

    // R2
    xfer_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> ($past(wr_en) && $past(core_halted) && ($past(win_ofs) == O_DST2)));

    // R2
    xfer_follows_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && core_halted && (win_ofs == O_DST2)) |=> xfer_req);

    // R4
    start_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> ($past(wr_en) && $past(core_halted) && ($past(win_ofs) == O_PCB)));

    // R4
    start_pc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (start_pc[7:0] == $past(wr_data)));

    // R4
    start_pc_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |-> $stable(start_pc));

    // R6
    status_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_STAT) |-> (rd_data == (core_halted ? 8'h02 : 8'h40)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_NONE) |-> (rd_data == 8'h00));

endmodule

bind cop_regwin cop_regwin_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_ofs     (win_ofs),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .core_halted (core_halted),
    .xfer_req    (xfer_req),
    .start_pulse (start_pulse),
    .start_pc    (start_pc),
    .region      (region)
);

// File: tb/cop_regwin_test.sv
`timescale 1ns/1ps
module cop_regwin_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  win_ofs = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        core_halted = 1'b1;
    logic        xfer_req;
    logic        start_pulse;
    logic [22:0] start_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cop_regwin uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_ofs     (win_ofs),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .core_halted (core_halted),
        .xfer_req    (xfer_req),
        .start_pulse (start_pulse),
        .start_pc    (start_pc)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_byte [int];   // plain stored bytes keyed by offset
    logic [7:0]  m_vec  [32];
    logic [23:0] m_gpr  [16];
    logic        e_xreq;
    logic        e_start;
    logic [22:0] e_spc;

    function automatic bit in_gpr(int a);
        return (a >= 'h380 && a <= 'h3AF) || (a >= 'h3C0 && a <= 'h3EF);
    endfunction

    task automatic model_reset();
        m_byte.delete();
        for (int i = 'h340; i <= 'h352; i++) m_byte[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_vec[i] = 8'h00;
        for (int i = 0; i < 16; i++) m_gpr[i] = 24'h0;
        e_xreq  = 1'b0;
        e_start = 1'b0;
        e_spc   = '0;
    endtask

    task automatic model_write(int a, logic [7:0] d, logic h);
        if (a >= 'h340 && a <= 'h352) begin
            case (a)
                'h348, 'h351, 'h352: m_byte[a] = d & 8'h01;
                'h34C:               m_byte[a] = d & 8'h03;
                'h34E:               m_byte[a] = d & 8'h7F;
                'h350:               m_byte[a] = d & 8'h77;
                default:             m_byte[a] = d;
            endcase
            if (a == 'h347 && h) e_xreq = 1'b1;
            if (a == 'h34F && h) begin
                e_start = 1'b1;
                e_spc   = 23'(m_byte['h34E]) * 23'd65536 + 23'(m_byte['h34D]) * 23'd256 + 23'(d);
            end
        end else if (a >= 'h360 && a <= 'h37F) begin
            m_vec[a % 32] = d;
        end else if (in_gpr(a)) begin
            m_gpr[(a % 64) / 3][((a % 64) % 3) * 8 +: 8] = d;
        end
    endtask

    function automatic logic [7:0] model_read(int a, logic h);
        if (a >= 'h340 && a <= 'h352) return m_byte[a];
        if (a >= 'h353 && a <= 'h35F) return h ? 8'h02 : 8'h40;
        if (a >= 'h360 && a <= 'h37F) return m_vec[a % 32];
        if (in_gpr(a)) return m_gpr[(a % 64) / 3][((a % 64) % 3) * 8 +: 8];
        return 8'h00;
    endfunction

    function automatic string tag_of(int a);
        if (a >= 'h340 && a <= 'h344) return "R1";
        if (a >= 'h345 && a <= 'h347) return "R1";
        if (a == 'h349 || a == 'h34A || a == 'h34B || a == 'h34D || a == 'h34E) return "R3";
        if (a == 'h34F) return "R4";
        if (a >= 'h340 && a <= 'h352) return "R5";
        if (a >= 'h353 && a <= 'h35F) return "R6";
        if (a >= 'h360 && a <= 'h37F) return "R7";
        if (in_gpr(a)) return "R8";
        return "R9";
    endfunction

    // model steps on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            e_xreq  = 1'b0;
            e_start = 1'b0;
            if (wr_en) model_write(int'(win_ofs), wr_data, core_halted);
        end
    end

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison of the pulse outputs against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_eq("R2", "xfer_req", 32'(xfer_req), 32'(e_xreq));
            check_eq("R4", "start_pulse", 32'(start_pulse), 32'(e_start));
            if (e_start) check_eq("R4", "start_pc", 32'(start_pc), 32'(e_spc));
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        win_ofs = 10'(a);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(int a);
        @(negedge clk);
        win_ofs = 10'(a);
        #1;
        check_eq(tag_of(a), $sformatf("read %03h", a), 32'(rd_data), 32'(model_read(a, core_halted)));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R10: outputs and storage are clear while in reset
        check_eq("R10", "xfer_req in reset", 32'(xfer_req), 32'h0);
        check_eq("R10", "start_pulse in reset", 32'(start_pulse), 32'h0);
        check_eq("R10", "start_pc in reset", 32'(start_pc), 32'h0);
        rst_n = 1'b1;
        for (int a = 'h340; a <= 'h352; a++) begin
            @(negedge clk);
            win_ofs = 10'(a);
            #1;
            check_eq("R10", $sformatf("reset read %03h", a), 32'(rd_data), 32'h0);
        end

        // R1: transfer fields with the core running, so no request
        core_halted = 1'b0;
        for (int a = 'h340; a <= 'h347; a++) wr(a, 8'(8'h11 * (a - 'h33F)));
        for (int a = 'h340; a <= 'h347; a++) rd_chk(a);

        // R2: trigger byte while halted
        core_halted = 1'b1;
        wr('h345, 8'hA5);
        wr('h346, 8'h5A);
        @(negedge clk);
        win_ofs = 10'h347; wr_data = 8'hC3; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check_eq("R2", "request after halted trigger", 32'(xfer_req), 32'h1);
        @(negedge clk);
        check_eq("R2", "request lasts one cycle", 32'(xfer_req), 32'h0);
        rd_chk('h347);

        // R3: program offset and page with high byte masking
        wr('h349, 8'h9A); wr('h34A, 8'hBC); wr('h34B, 8'hDE);
        wr('h34D, 8'h34); wr('h34E, 8'hD2);
        for (int a = 'h349; a <= 'h34E; a++) rd_chk(a);
        rd_chk('h34E);
        check_eq("R3", "page high masked", 32'(rd_data), 32'h52);

        // R4: start only when halted; start address = page*256 + byte
        core_halted = 1'b0;
        wr('h34F, 8'h77);
        rd_chk('h34F);
        core_halted = 1'b1;
        @(negedge clk);
        win_ofs = 10'h34F; wr_data = 8'h56; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check_eq("R4", "start pulse", 32'(start_pulse), 32'h1);
        check_eq("R4", "start address", 32'(start_pc), 32'h523456);
        rd_chk('h34F);

        // R5: configuration masks
        foreach (m_vec[i]) begin end
        wr('h348, 8'hFF); wr('h34C, 8'hFF); wr('h350, 8'hFF);
        wr('h351, 8'hFF); wr('h352, 8'hFE);
        rd_chk('h348); rd_chk('h34C); rd_chk('h350); rd_chk('h351); rd_chk('h352);
        wr('h352, 8'h03);
        rd_chk('h352);
        check_eq("R5", "cfg byte at 350", 32'(model_read('h350, 1'b1)), 32'h77);

        // R6: status across its range in both core states
        for (int a = 'h353; a <= 'h35F; a++) rd_chk(a);
        core_halted = 1'b0;
        for (int a = 'h353; a <= 'h35F; a++) rd_chk(a);
        core_halted = 1'b1;

        // R7: vector table
        for (int i = 0; i < 32; i++) wr('h360 + i, 8'(8'h80 + i * 3));
        for (int i = 0; i < 32; i++) rd_chk('h360 + i);

        // R8: write low mirror, read high mirror, then the reverse
        for (int i = 0; i < 48; i++) wr('h380 + i, 8'(i * 5 + 1));
        for (int i = 0; i < 48; i++) rd_chk('h3C0 + i);
        wr('h3C0 + 3 * 7 + 2, 8'hE7);
        wr('h3C0 + 3 * 15, 8'h4B);
        rd_chk('h380 + 3 * 7 + 2);
        rd_chk('h380 + 3 * 15);
        rd_chk('h380 + 3 * 7 + 1);

        // R9: writes outside the mapped ranges, then a full sweep
        wr('h000, 8'hFF); wr('h33F, 8'hFF); wr('h355, 8'hFF);
        wr('h3B0, 8'hFF); wr('h3BF, 8'hFF); wr('h3F5, 8'hFF); wr('h3FF, 8'hFF);
        for (int a = 0; a < 1024; a++) rd_chk(a);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule